// File: doc/BRIEF.md
# Addressable RGB LED Serial Encoder

This block turns one 24-bit colour word into the single-wire, pulse-width-coded waveform that chained smart RGB LEDs expect. A word arrives as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. It is accepted through a valid/ready handshake. The encoder first holds its output low for a latch interval. It then sends the three colour bytes in the order the LEDs want: green, then red, then blue, with the most significant bit of each byte first.

Each bit on the wire is a high phase followed by a low phase. A 1 bit has a long high phase and a short low phase; a 0 bit has the reverse. All durations are whole clock cycles, computed at elaboration from the clock-frequency parameter. A second parameter selects the timing set for a second LED variant. Only one word is handled at a time, and the next word is taken only after the last low phase has ended.

The control is a four-state machine:
- `ST_IDLE` goes to `ST_LATCH` on acceptance.
- `ST_LATCH` goes to `ST_MARK` when the latch timer runs out.
- `ST_MARK` goes to `ST_SPACE` when the high-phase timer runs out.
- `ST_SPACE` goes back to `ST_MARK` for the next bit. After the 24th bit it goes to `ST_IDLE` instead.

Top module: `led_strip_encoder`

## Requirements
- R1: `pix_ready` is high only in `ST_IDLE`. A word is taken on a rising clock edge where `pix_valid` and `pix_ready` are both high. In the cycle after acceptance, `pix_ready` is low and `busy` is high.
- R2: `led_dout` is low whenever the block is idle and while `rst` is high. `busy` is high from the acceptance edge until the edge at which the final low phase ends.
- R3: After acceptance, `led_dout` stays low for the latch interval before the first high phase. This is at least 50 us with the default set (VARIANT=0) and at least 80 us with VARIANT=1.
- R4: The wire order is green byte (`pix_rgb[15:8]`), then red byte (`pix_rgb[23:16]`), then blue byte (`pix_rgb[7:0]`).
- R5: Within each byte, bits go out most significant bit first. Exactly 24 bits are sent per word.
- R6: With VARIANT=0, a 0 bit is high for 0.4 us and then low for 0.85 us, each within ±150 ns.
- R7: With VARIANT=0, a 1 bit is high for 0.8 us and then low for 0.45 us, each within ±150 ns.
- R8: With VARIANT=1, the timing is: 0 bit high 0.3 us and low 0.9 us; 1 bit high 0.6 us and low 0.6 us; latch 80 us. Each bit phase is within ±150 ns.
- R9: Each phase lasts exactly floor(duration × CLK_HZ / 1e9) cycles. An elaboration-time check requires every such count to be at least 1.
- R10: While `busy` is high, `pix_valid` and `pix_rgb` are ignored. The word in flight is sent unchanged, and no extra word is started.
- R11: A synchronous `rst` in the middle of a word returns the block to `ST_IDLE`, with `led_dout` low, `busy` low and `pix_ready` high, one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Colour word offered |
| pix_rgb | input | 24 | Colour word, red in 23:16, green in 15:8, blue in 7:0 |
| pix_ready | output | 1 | High while idle; the word is taken when valid is also high |
| led_dout | output | 1 | Pulse-width-coded serial line to the LED chain |
| busy | output | 1 | High from acceptance until the final low phase ends |

## Verification
The clocked properties assume that `rst` is held high over the first edges. They also assume that `pix_valid` and `pix_rgb` change only between edges, so the state and the line are always defined when a property samples them. The stimulus drives every input on the falling edge and begins with several cycles of reset. In the stimulus, `pix_valid` is raised while the block is busy only for a short burst, which ends well before the last low phase. Because of this, the check for a second, unwanted word looks only at the window after completion.

// File: rtl/ledenc_pkg.sv
package ledenc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_MARK,
        ST_SPACE
    } enc_state_e;

    // Nominal durations in nanoseconds
    typedef struct packed {
        int unsigned t0h;
        int unsigned t1h;
        int unsigned t0l;
        int unsigned t1l;
        int unsigned latch;
    } ns_set_t;

    function automatic ns_set_t timing_ns(input int variant);
        ns_set_t s;
        if (variant == 1) begin
            s.t0h = 300; s.t1h = 600; s.t0l = 900; s.t1l = 600; s.latch = 80000;
        end else begin
            s.t0h = 400; s.t1h = 800; s.t0l = 850; s.t1l = 450; s.latch = 50000;
        end
        return s;
    endfunction

    // floor(ns * hz / 1e9)
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input longint unsigned hz);
        logic [63:0] p;
        p = (64'(ns) * 64'(hz)) / 64'd1_000_000_000;
        return p[31:0];
    endfunction

endpackage

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/led_grb_shifter.sv
module led_grb_shifter #(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [3*CH_W-1:0] rgb_i,
    input  logic              shift,
    output logic              cur_bit,
    output logic              nxt_bit,
    output logic              last_bit
);

    localparam int WORD_W = 3 * CH_W;
    localparam int IDX_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] grb;
    logic [WORD_W-1:0] sh;
    logic [IDX_W-1:0]  idx;

    // Wire order: green, red, blue
    assign grb = {rgb_i[2*CH_W-1:CH_W], rgb_i[3*CH_W-1:2*CH_W], rgb_i[CH_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= grb;
            idx <= '0;
        end else if (shift) begin
            sh  <= {sh[WORD_W-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end

    assign cur_bit  = sh[WORD_W-1];
    assign nxt_bit  = sh[WORD_W-2];
    assign last_bit = (idx == IDX_W'(WORD_W - 1));

    // R5
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        shift |-> !last_bit);

endmodule

// File: rtl/led_strip_encoder.sv
module led_strip_encoder
    import ledenc_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 250_000_000,
    parameter int              VARIANT = 0,
    parameter int              CH_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [3*CH_W-1:0] pix_rgb,
    output logic              pix_ready,
    output logic              led_dout,
    output logic              busy
);

    localparam ns_set_t     NS      = timing_ns(VARIANT);
    localparam int unsigned T0H_C   = ns_to_cycles(NS.t0h, CLK_HZ);
    localparam int unsigned T1H_C   = ns_to_cycles(NS.t1h, CLK_HZ);
    localparam int unsigned T0L_C   = ns_to_cycles(NS.t0l, CLK_HZ);
    localparam int unsigned T1L_C   = ns_to_cycles(NS.t1l, CLK_HZ);
    localparam int unsigned LATCH_C = ns_to_cycles(NS.latch, CLK_HZ);
    localparam int unsigned MAX_HI  = (T0H_C > T1H_C) ? T0H_C : T1H_C;
    localparam int unsigned MAX_LO  = (T0L_C > T1L_C) ? T0L_C : T1L_C;
    localparam int unsigned MAX_PH  = (MAX_HI > MAX_LO) ? MAX_HI : MAX_LO;
    localparam int unsigned MAX_C   = (LATCH_C > MAX_PH) ? LATCH_C : MAX_PH;
    localparam int          CNT_W   = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0] T0H_L   = CNT_W'(T0H_C - 1);
    localparam logic [CNT_W-1:0] T1H_L   = CNT_W'(T1H_C - 1);
    localparam logic [CNT_W-1:0] T0L_L   = CNT_W'(T0L_C - 1);
    localparam logic [CNT_W-1:0] T1L_L   = CNT_W'(T1L_C - 1);
    localparam logic [CNT_W-1:0] LATCH_L = CNT_W'(LATCH_C - 1);

    // R9
    initial begin
        cyc_min_chk: assert (T0H_C >= 1 && T1H_C >= 1 && T0L_C >= 1 &&
                             T1L_C >= 1 && LATCH_C >= 1)
            else $error("phase cycle count below one");
    end

    enc_state_e       st, st_nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             word_load;
    logic             bit_shift;
    logic             cur_bit, nxt_bit, last_bit;

    led_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    led_grb_shifter #(.CH_W(CH_W)) shifter_i (
        .clk      (clk),
        .rst      (rst),
        .load     (word_load),
        .rgb_i    (pix_rgb),
        .shift    (bit_shift),
        .cur_bit  (cur_bit),
        .nxt_bit  (nxt_bit),
        .last_bit (last_bit)
    );

    // Next state and datapath controls
    always_comb begin
        st_nxt    = st;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        word_load = 1'b0;
        bit_shift = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (pix_valid) begin
                    st_nxt    = ST_LATCH;
                    tmr_load  = 1'b1;
                    tmr_val   = LATCH_L;
                    word_load = 1'b1;
                end
            end
            ST_LATCH: begin
                if (tmr_expired) begin
                    st_nxt   = ST_MARK;
                    tmr_load = 1'b1;
                    tmr_val  = cur_bit ? T1H_L : T0H_L;
                end
            end
            ST_MARK: begin
                if (tmr_expired) begin
                    st_nxt   = ST_SPACE;
                    tmr_load = 1'b1;
                    tmr_val  = cur_bit ? T1L_L : T0L_L;
                end
            end
            ST_SPACE: begin
                if (tmr_expired) begin
                    if (last_bit) begin
                        st_nxt = ST_IDLE;
                    end else begin
                        st_nxt    = ST_MARK;
                        tmr_load  = 1'b1;
                        tmr_val   = nxt_bit ? T1H_L : T0H_L;
                        bit_shift = 1'b1;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    // Registered line output, aligned with the state it belongs to
    always_ff @(posedge clk) begin
        if (rst) led_dout <= 1'b0;
        else     led_dout <= (st_nxt == ST_MARK);
    end

    assign pix_ready = (st == ST_IDLE);
    assign busy      = (st != ST_IDLE);

    // R1
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_ready) |=> (busy && !pix_ready));

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !led_dout);

    // R3
    latch_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LATCH) |-> !led_dout);

    // R6
    mark_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MARK) |-> led_dout);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !led_dout);

    // R10
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && tmr_load) |-> tmr_expired);

endmodule

// File: tb/led_strip_encoder_tb.sv
module led_strip_encoder_tb_top;

    localparam int PER_NS   = 4;
    localparam int WDOG_CYC = 180000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_a = 1'b0, valid_b = 1'b0;
    logic [23:0] rgb = '0;
    logic        ready_a, dout_a, busy_a;
    logic        ready_b, dout_b, busy_b;
    logic        sel = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    led_strip_encoder #(.CLK_HZ(250_000_000), .VARIANT(0)) dut_i (
        .clk(clk), .rst(rst), .pix_valid(valid_a), .pix_rgb(rgb),
        .pix_ready(ready_a), .led_dout(dout_a), .busy(busy_a)
    );

    led_strip_encoder #(.CLK_HZ(250_000_000), .VARIANT(1)) dut_alt_i (
        .clk(clk), .rst(rst), .pix_valid(valid_b), .pix_rgb(rgb),
        .pix_ready(ready_b), .led_dout(dout_b), .busy(busy_b)
    );

    logic m_d, m_b, m_r;
    assign m_d = sel ? dout_b  : dout_a;
    assign m_b = sel ? busy_b  : busy_a;
    assign m_r = sel ? ready_b : ready_a;

    // Nominal ns per selected set
    int n_t0h, n_t1h, n_t0l, n_t1l, n_lat;
    always_comb begin
        if (sel) begin
            n_t0h = 300; n_t1h = 600; n_t0l = 900; n_t1l = 600; n_lat = 80000;
        end else begin
            n_t0h = 400; n_t1h = 800; n_t0l = 850; n_t1l = 450; n_lat = 50000;
        end
    end

    // Waveform monitor: run lengths in cycles
    int   hw [24];
    int   lw [24];
    logic bv [24];
    int   nb = 0, lat_len = 0, run = 0;
    logic pd = 1'b0, pb = 1'b0, have_hi = 1'b0;

    always @(negedge clk) begin
        if (m_b) begin
            if (!pb) begin
                nb = 0; run = 1; have_hi = 1'b0; lat_len = 0;
            end else if (m_d != pd) begin
                if (pd) begin
                    if (nb < 24) begin
                        hw[nb] = run;
                        bv[nb] = (run * PER_NS) > ((n_t0h + n_t1h) / 2);
                    end
                    have_hi = 1'b1;
                end else if (!have_hi) begin
                    lat_len = run;
                end else begin
                    if (nb < 24) lw[nb] = run;
                    nb++;
                end
                run = 1;
            end else begin
                run++;
            end
        end else if (pb) begin
            if (nb < 24) lw[nb] = run;
            nb++;
        end
        pd = m_d;
        pb = m_b;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int cyc_of(input int ns);
        return (ns * 250) / 1000;
    endfunction

    task automatic check_reset_state();
        @(negedge clk);
        chk(ready_a && !busy_a, "R1", "ready/busy after reset", {30'd0, ready_a, busy_a}, 2);
        chk(!dout_a && !dout_b, "R2", "line low after reset", {30'd0, dout_a, dout_b}, 0);
    endtask

    // Send a word on the selected instance and check its waveform
    task automatic send_word(input logic s, input logic [23:0] w, input bit noise);
        logic [23:0] grb;
        int bad_bit, bad_hi, bad_lo, bad_cyc, first;
        sel = s;
        grb = {w[15:8], w[23:16], w[7:0]};
        @(negedge clk);
        rgb = w;
        if (s) valid_b = 1'b1; else valid_a = 1'b1;
        @(negedge clk);
        chk(!m_r && m_b, "R1", "ready low busy high after accept", {30'd0, m_r, m_b}, 1);
        valid_a = 1'b0; valid_b = 1'b0;
        if (noise) begin
            repeat (20) @(negedge clk);
            rgb = ~w;
            if (s) valid_b = 1'b1; else valid_a = 1'b1;
            repeat (50) @(negedge clk);
            valid_a = 1'b0; valid_b = 1'b0;
        end
        while (m_b) @(negedge clk);
        @(negedge clk);
        chk(m_r && !m_d, "R2", "idle and low after word", {30'd0, m_r, m_d}, 2);
        chk(nb == 24, "R5", "bit count", nb, 24);
        chk(lat_len * PER_NS >= n_lat, s ? "R8" : "R3", "latch ns", lat_len * PER_NS, n_lat);
        chk(lat_len == cyc_of(n_lat), "R9", "latch cycles", lat_len, cyc_of(n_lat));
        bad_bit = 0; bad_hi = 0; bad_lo = 0; bad_cyc = 0; first = -1;
        for (int i = 0; i < 24; i++) begin
            int eh, el, dh, dl;
            eh = grb[23-i] ? n_t1h : n_t0h;
            el = grb[23-i] ? n_t1l : n_t0l;
            dh = hw[i] * PER_NS - eh;
            dl = lw[i] * PER_NS - el;
            if (bv[i] != grb[23-i]) begin
                bad_bit++;
                if (first < 0) first = i;
            end
            if (dh > 150 || dh < -150) bad_hi++;
            if (dl > 150 || dl < -150) bad_lo++;
            if (hw[i] != cyc_of(eh) || lw[i] != cyc_of(el)) bad_cyc++;
        end
        chk(bad_bit == 0, noise ? "R10" : "R4", "GRB MSB-first bits wrong, first index", first, -1);
        chk(bad_hi == 0, s ? "R8" : "R6", "high phases out of window", bad_hi, 0);
        chk(bad_lo == 0, s ? "R8" : "R7", "low phases out of window", bad_lo, 0);
        chk(bad_cyc == 0, "R9", "phases not floor cycle count", bad_cyc, 0);
        if (noise) begin
            repeat (30) @(negedge clk);
            chk(m_r && !m_b && !m_d, "R10", "no extra word started", {29'd0, m_r, m_b, m_d}, 4);
        end
    endtask

    task automatic reset_mid_word();
        sel = 1'b0;
        @(negedge clk);
        rgb = 24'hFFFFFF;
        valid_a = 1'b1;
        @(negedge clk);
        valid_a = 1'b0;
        repeat (13000) @(negedge clk);
        chk(busy_a, "R11", "busy before reset", {31'd0, busy_a}, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!dout_a && ready_a && !busy_a, "R11", "state after reset",
            {29'd0, dout_a, ready_a, busy_a}, 2);
        chk(!dout_a, "R2", "line low during reset", {31'd0, dout_a}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WDOG_CYC, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check_reset_state();
        send_word(1'b0, 24'hFF00AA, 1'b0);
        send_word(1'b0, 24'hA5C33C, 1'b0);
        send_word(1'b0, 24'h123456, 1'b1);
        reset_mid_word();
        send_word(1'b1, 24'h3C0FF1, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule